// File: doc/BRIEF.md
# Column-Compressed Unsigned Multiplier

This block multiplies two unsigned operands of independent widths and returns the complete product, with no truncation. It has no clock and no state. Every operand-bit pair is ANDed, and the result lands in the column that matches its binary weight. The columns are then compressed in a series of height-limited stages, using only three-input and two-input counters. Once no column holds more than two bits, a single carry-propagate adder sums the two remaining rows.

The stages follow a shrinking ladder of height limits. The limits are 2, 3, 4, 6, 9, 13 and so on, each one the previous times one and a half, rounded down. A stage adds only as many counters as it needs to bring every column down to its limit. The block also reports a figure for the gate levels spent in the compression tree. A bench or a timing review can compare this figure against the stage count.

Top module: `dadda_mult`

## Requirements
- R1: `product` equals the unsigned product of `op_a` and `op_b` for every operand pair, and it is `A_W+B_W` bits wide.
- R2: When either operand is zero, `product` is zero.
- R3: When one operand is 1, `product` equals the other operand, zero-extended.
- R4: When both operands are all ones, `product` is (2^A_W-1)(2^B_W-1). For 8 by 8 this is 0xFE01.
- R5: After compression, no column holds more than two bits. The two rows, added in the final adder, give `product`, and that adder never carries out of the top bit.
- R6: A three-input counter costs 4 levels and a two-input counter costs 3. `tree_levels` reports the worst accumulated level over all columns. Let S be the number of ladder limits below min(A_W,B_W). The value then lies between 3·S and 4·S: 12 to 16 for 8 by 8, and 3 to 4 for 5 by 3.
- R7: Unequal operand widths, for example 5 by 3, give exact products under R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | A_W | First unsigned operand |
| op_b | input | B_W | Second unsigned operand |
| product | output | A_W+B_W | Full unsigned product |
| tree_levels | output | LVL_W | Worst-case gate-level estimate of the compression tree |

## Verification
If a counter were wired to the wrong column, or a stage dropped a bit, the product would be wrong at once. It would show on the first operand pair whose partial products reach that column. Because the block is purely combinational, no error can hide behind a delay. Sweeping every operand pair therefore exposes any misplaced weight within that sweep. All-ones operands drive the longest carry chain through the final adder. The two-row sum and the final carry-out are also checked whenever the operands change.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

    localparam int FA_LEVELS = 4;
    localparam int HA_LEVELS = 3;

    function automatic int imin(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // number of ladder limits strictly below the starting height
    function automatic int stage_count(input int height);
        int lim;
        int cnt;
        lim = 2;
        cnt = 0;
        while (lim < height) begin
            cnt = cnt + 1;
            lim = (lim * 3) / 2;
        end
        return cnt;
    endfunction

    // ladder limit with index idx (0 -> 2, 1 -> 3, 2 -> 4, 3 -> 6 ...)
    function automatic int limit_at(input int idx);
        int lim;
        lim = 2;
        for (int k = 0; k < idx; k++) begin
            lim = (lim * 3) / 2;
        end
        return lim;
    endfunction

endpackage

// File: rtl/pp_array.sv
module pp_array #(
    parameter int A_W = 8,
    parameter int B_W = 8
) (
    input  logic [A_W-1:0]     op_a,
    input  logic [B_W-1:0]     op_b,
    output logic [A_W*B_W-1:0] pp_bits
);
    // bit (i*B_W + j) carries weight i+j
    for (genvar i = 0; i < A_W; i++) begin : g_row
        for (genvar j = 0; j < B_W; j++) begin : g_col
            assign pp_bits[i*B_W + j] = op_a[i] & op_b[j];
        end
    end
endmodule

// File: rtl/column_compress.sv
module column_compress
    import dadda_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int B_W   = 8,
    parameter int LVL_W = 8
) (
    input  logic [A_W*B_W-1:0]   pp_bits,
    output logic [A_W+B_W-1:0]   row_s,
    output logic [A_W+B_W-1:0]   row_c,
    output logic [LVL_W-1:0]     tree_levels
);
    localparam int PW     = A_W + B_W;
    localparam int MINW   = imin(A_W, B_W);
    localparam int MAXH   = imax(MINW, 2);
    localparam int STAGES = stage_count(MINW);

    logic cur_b [PW][MAXH];
    int   cur_h [PW];
    int   cur_l [PW];
    logic nxt_b [PW][MAXH];
    int   nxt_h [PW];
    int   nxt_l [PW];
    int   tot;
    int   take;
    int   lim;
    int   lvl;
    int   worst;
    logic bx, by, bz, s_bit, c_bit;

    always_comb begin
        tot = 0; take = 0; lim = 2; lvl = 0; worst = 0;
        bx = 1'b0; by = 1'b0; bz = 1'b0; s_bit = 1'b0; c_bit = 1'b0;
        for (int c = 0; c < PW; c++) begin
            cur_h[c] = 0; cur_l[c] = 0; nxt_h[c] = 0; nxt_l[c] = 0;
            for (int k = 0; k < MAXH; k++) begin
                cur_b[c][k] = 1'b0;
                nxt_b[c][k] = 1'b0;
            end
        end

        // drop every partial product into its weight column
        for (int i = 0; i < A_W; i++) begin
            for (int j = 0; j < B_W; j++) begin
                if (cur_h[i+j] < MAXH) begin
                    cur_b[i+j][cur_h[i+j]] = pp_bits[i*B_W + j];
                    cur_h[i+j] = cur_h[i+j] + 1;
                end
            end
        end

        // stages, tallest limit first
        for (int st = STAGES - 1; st >= 0; st--) begin
            lim = limit_at(st);
            for (int c = 0; c < PW; c++) begin
                nxt_h[c] = 0;
                nxt_l[c] = 0;
                for (int k = 0; k < MAXH; k++) nxt_b[c][k] = 1'b0;
            end
            for (int c = 0; c < PW; c++) begin
                tot  = cur_h[c] + nxt_h[c];
                take = 0;
                for (int r = 0; r < MAXH; r++) begin
                    if (tot > lim) begin
                        if ((tot - lim >= 2) && (take + 3 <= cur_h[c])) begin
                            bx    = cur_b[c][take];
                            by    = cur_b[c][take+1];
                            bz    = cur_b[c][take+2];
                            s_bit = bx ^ by ^ bz;
                            c_bit = (bx & by) | (bz & (bx ^ by));
                            lvl   = cur_l[c] + FA_LEVELS;
                            take  = take + 3;
                            tot   = tot - 2;
                        end else if (take + 2 <= cur_h[c]) begin
                            bx    = cur_b[c][take];
                            by    = cur_b[c][take+1];
                            s_bit = bx ^ by;
                            c_bit = bx & by;
                            lvl   = cur_l[c] + HA_LEVELS;
                            take  = take + 2;
                            tot   = tot - 1;
                        end else begin
                            tot = lim;
                            lvl = -1;
                        end
                        if (lvl >= 0) begin
                            if (nxt_h[c] < MAXH) begin
                                nxt_b[c][nxt_h[c]] = s_bit;
                                nxt_h[c] = nxt_h[c] + 1;
                            end
                            nxt_l[c] = imax(nxt_l[c], lvl);
                            if ((c + 1 < PW) && (nxt_h[c+1] < MAXH)) begin
                                nxt_b[c+1][nxt_h[c+1]] = c_bit;
                                nxt_h[c+1] = nxt_h[c+1] + 1;
                                nxt_l[c+1] = imax(nxt_l[c+1], lvl);
                            end
                        end
                    end
                end
                // untouched bits pass straight through
                for (int q = 0; q < MAXH; q++) begin
                    if ((q >= take) && (q < cur_h[c]) && (nxt_h[c] < MAXH)) begin
                        nxt_b[c][nxt_h[c]] = cur_b[c][q];
                        nxt_h[c] = nxt_h[c] + 1;
                        nxt_l[c] = imax(nxt_l[c], cur_l[c]);
                    end
                end
            end
            for (int c = 0; c < PW; c++) begin
                cur_h[c] = nxt_h[c];
                cur_l[c] = nxt_l[c];
                for (int k = 0; k < MAXH; k++) cur_b[c][k] = nxt_b[c][k];
            end
        end

        for (int c = 0; c < PW; c++) begin
            row_s[c] = (cur_h[c] > 0) ? cur_b[c][0] : 1'b0;
            row_c[c] = (cur_h[c] > 1) ? cur_b[c][1] : 1'b0;
            worst    = imax(worst, cur_l[c]);
        end
        tree_levels = LVL_W'(worst);
    end
endmodule

// File: rtl/ripple_cpa.sv
module ripple_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;

    assign cy[0] = 1'b0;
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum[k]  = x[k] ^ y[k] ^ cy[k];
        assign cy[k+1] = (x[k] & y[k]) | (cy[k] & (x[k] ^ y[k]));
    end
    assign cout = cy[W];
endmodule

// File: rtl/dadda_mult.sv
module dadda_mult #(
    parameter int A_W   = 8,
    parameter int B_W   = 8,
    parameter int LVL_W = 8
) (
    input  logic [A_W-1:0]     op_a,
    input  logic [B_W-1:0]     op_b,
    output logic [A_W+B_W-1:0] product,
    output logic [LVL_W-1:0]   tree_levels
);
    localparam int PW = A_W + B_W;

    logic [A_W*B_W-1:0] pp_bits;
    logic [PW-1:0]      row_s;
    logic [PW-1:0]      row_c;
    logic               cpa_cout;

    pp_array #(.A_W(A_W), .B_W(B_W)) u_pp (
        .op_a    (op_a),
        .op_b    (op_b),
        .pp_bits (pp_bits)
    );

    column_compress #(.A_W(A_W), .B_W(B_W), .LVL_W(LVL_W)) u_tree (
        .pp_bits     (pp_bits),
        .row_s       (row_s),
        .row_c       (row_c),
        .tree_levels (tree_levels)
    );

    ripple_cpa #(.W(PW)) u_cpa (
        .x    (row_s),
        .y    (row_c),
        .sum  (product),
        .cout (cpa_cout)
    );
endmodule

// File: rtl/dadda_mult_chk.sv
module dadda_mult_chk #(
    parameter int A_W = 8,
    parameter int B_W = 8
) (
    input logic [A_W-1:0]     op_a,
    input logic [B_W-1:0]     op_b,
    input logic [A_W+B_W-1:0] product,
    input logic [A_W+B_W-1:0] row_s,
    input logic [A_W+B_W-1:0] row_c,
    input logic               cpa_cout
);
    localparam int PW = A_W + B_W;

    always_comb begin
        // R1
        product_ok_chk: assert (product == (PW'(op_a) * PW'(op_b)));
        // R2
        if ((op_a == '0) || (op_b == '0)) begin
            zero_operand_chk: assert (product == '0);
        end
        // R3
        if (op_b == B_W'(1)) begin
            unit_operand_chk: assert (product == PW'(op_a));
        end
        // R5
        two_rows_chk: assert (PW'(row_s + row_c) == product);
        // R5
        no_carry_out_chk: assert (cpa_cout == 1'b0);
    end
endmodule

bind dadda_mult dadda_mult_chk #(.A_W(A_W), .B_W(B_W)) chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .product  (product),
    .row_s    (row_s),
    .row_c    (row_c),
    .cpa_cout (cpa_cout)
);

// File: tb/dadda_mult_test.sv
module dadda_mult_test;
    localparam int CYC = 20;

    logic clk = 1'b0;
    always #(CYC/2) clk = ~clk;

    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [7:0]  lv8;
    logic [4:0]  a5;
    logic [2:0]  b3;
    logic [7:0]  p53;
    logic [7:0]  lv53;

    int n_vec  = 0;
    int n_fail = 0;

    dadda_mult #(.A_W(8), .B_W(8), .LVL_W(8)) uut (
        .op_a(a8), .op_b(b8), .product(p8), .tree_levels(lv8)
    );

    dadda_mult #(.A_W(5), .B_W(3), .LVL_W(8)) uut_narrow (
        .op_a(a5), .op_b(b3), .product(p53), .tree_levels(lv53)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        n_vec++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic run_all();
        string tag;
        a8 = '0; b8 = '0; a5 = '0; b3 = '0;
        @(negedge clk);
        check("R2 idle zero 8x8", int'(p8), 0);
        check("R2 idle zero 5x3", int'(p53), 0);
        // R6: ladder below 8 is 2,3,4,6 -> S=4; below 3 is 2 -> S=1
        check_range("R6 levels 8x8", int'(lv8), 12, 16);
        check_range("R6 R7 levels 5x3", int'(lv53), 3, 4);

        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                @(posedge clk);
                a8 = 8'(x); b8 = 8'(y);
                @(negedge clk);
                if (x == 0 || y == 0)          tag = "R2 zero operand";
                else if (x == 1 || y == 1)     tag = "R3 unit operand";
                else if (x == 255 && y == 255) tag = "R4 R5 all ones";
                else                           tag = "R1 R5 product";
                check(tag, int'(p8), x * y);
            end
        end
        check("R4 all ones 0xFE01", int'(p8), 32'hFE01);

        for (int x = 0; x < 32; x++) begin
            for (int y = 0; y < 8; y++) begin
                @(posedge clk);
                a5 = 5'(x); b3 = 3'(y);
                @(negedge clk);
                check("R7 R1 narrow product", int'(p53), x * y);
            end
        end
        check("R7 R4 narrow all ones", int'(p53), 31 * 7);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                n_fail++;
                $display("FAIL R1 watchdog expired actual=%0d expected=done", n_vec);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule